// File: doc/BRIEF.md
# Two-wire register-file slave with counter capture

This block is the serial front end of a 256-byte register and storage space on a standard two-wire (I2C) bus. It watches the bus for START and STOP conditions and compares the first byte after START with its own 7-bit device address. On a write, it takes a word-address byte and then any number of data bytes, and sends each one to the register space through a single-cycle write strobe. On a read, it shifts bytes out of the register space. A single byte pointer advances after every byte, whether written or read, and rolls from 0xFF back to 0x00.

Seven time-counter bytes, which the block sees at locations 0x01 to 0x07, are sampled into capture registers when a read transaction is accepted. Every byte read from those locations during that transaction comes from the capture, so a carry that ripples through the live counters cannot tear the value the master receives. Both bus lines are synchronised and deglitched in the system clock domain. The block only ever pulls SDA low, and it never drives SCL.

States: `ST_IDLE` (bus ignored until START), `ST_DEV` (device byte shifting in), `ST_DEV_ACK` (acknowledging the device byte), `ST_WORD` and `ST_WORD_ACK` (word address), `ST_WRITE` and `ST_WRITE_ACK` (data bytes from the master), `ST_READ` (data bytes to the master) and `ST_READ_ACK` (the master's acknowledge bit). Transitions: any state goes to `ST_DEV` on START and to `ST_IDLE` on STOP. `ST_DEV` goes to `ST_DEV_ACK` on an address hit, or to `ST_IDLE` on a miss. `ST_DEV_ACK` goes to `ST_READ` when R/W=1, otherwise to `ST_WORD`. `ST_WORD` goes to `ST_WORD_ACK`, then to `ST_WRITE`. `ST_WRITE` and `ST_WRITE_ACK` alternate. `ST_READ` goes to `ST_READ_ACK`, which returns to `ST_READ` on a master ACK and goes to `ST_IDLE` on a NACK.

Top module: `i2crf_slave`

## Requirements
- R1: After reset the block is idle, SDA is released (`sda_oe`=0), `mem_we`=0 and the byte pointer is 0x00.
- R2: The device address is the 7-bit value {1,0,1,0,0,0,`addr_sel`}, sent MSB first and followed by the R/W bit. On a match the block acknowledges the byte. On a mismatch it leaves SDA released, acknowledges nothing and writes nothing until the next START.
- R3: In a write transaction (R/W=0), the byte after the device address loads the pointer. Each following data byte is acknowledged and produces exactly one single-cycle `mem_we` pulse carrying that byte on `mem_wdata` at the current pointer on `mem_addr`.
- R4: The pointer increments by one after every data byte written or read, and wraps from 0xFF to 0x00.
- R5: A write of the word address, followed by a repeated START with R/W=1, returns bytes starting at that word address.
- R6: A read issued directly after the device byte (R/W=1) continues from the current pointer. Straight after reset, that pointer is 0x00.
- R7: When a read device byte is accepted, the seven bytes of `cnt_live` are captured. Byte k (bits 8k+7..8k) is captured for location k+1. Reads of locations 0x01 to 0x07 return the captured value, unaffected by later changes of `cnt_live`, until the next accepted read. All other locations return `mem_rdata`.
- R8: A master NACK after a read byte ends the transfer. The block then keeps SDA released through any further clocking until the next START.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. STOP returns the block to idle from any state, and START restarts address reception from any state.
- R10: The block changes `sda_oe` only while the filtered SCL is low, except on START and STOP.
- R11: A pulse on SCL shorter than `FILT_LEN` system clocks is ignored and adds no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Strap that supplies the lowest device address bit |
| cnt_live | input | N_CNT*8 | Live counter bytes for locations 0x01 upward |
| mem_rdata | input | 8 | Read data of the register space at `mem_addr` |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| mem_addr | output | 8 | Byte pointer / register-space address |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_wdata | output | 8 | Write data |

## Verification
The hardest case to reach is a change of the live counters in the middle of a read burst that has already passed location 0x01. The bench starts a random read at 0x01, changes every `cnt_live` byte after the first byte has been shifted out, and then expects all seven bytes to match the values captured when the device byte was accepted. A second burst must then show the new values. Glitches on SCL are placed inside the low phase of a data bit, where a missed filter would shift in an extra bit and corrupt the stored byte. A misaddressed transaction is followed by more bytes to show that nothing is acknowledged or written.

// File: rtl/i2crf_pkg.sv
package i2crf_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WRITE,
        ST_WRITE_ACK,
        ST_READ,
        ST_READ_ACK
    } rf_state_t;

endpackage

// File: rtl/i2crf_line_filter.sv
module i2crf_line_filter #(
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int FCW = $clog2(FILT_LEN + 1);

    logic [SYNC_LEN-1:0] sync_q;
    logic [FCW-1:0]      run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            run_q  <= '0;
            clean  <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], raw};
            if (sync_q[SYNC_LEN-1] == clean) begin
                run_q <= '0;
            end else if (run_q == FCW'(FILT_LEN - 1)) begin
                clean <= sync_q[SYNC_LEN-1];
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2crf_bus_events.sv
module i2crf_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        scl_rise = scl & ~scl_q;
        scl_fall = ~scl & scl_q;
        ev_start = scl & scl_q & sda_q & ~sda;
        ev_stop  = scl & scl_q & ~sda_q & sda;
    end
endmodule

// File: rtl/i2crf_snapshot.sv
module i2crf_snapshot
    import i2crf_pkg::*;
#(
    parameter int N_CNT = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    capture,
    input  logic [N_CNT*BYTE_W-1:0] live,
    input  logic [BYTE_W-1:0]       ptr,
    input  logic [BYTE_W-1:0]       ext_rdata,
    output logic [BYTE_W-1:0]       rd_byte,
    output logic [N_CNT*BYTE_W-1:0] snap_flat
);
    logic [BYTE_W-1:0] snap_q [N_CNT];

    for (genvar k = 0; k < N_CNT; k++) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                snap_q[k] <= '0;
            end else if (capture) begin
                snap_q[k] <= live[k*BYTE_W +: BYTE_W];
            end
        end
        assign snap_flat[k*BYTE_W +: BYTE_W] = snap_q[k];
    end

    always_comb begin
        rd_byte = ext_rdata;
        for (int k = 0; k < N_CNT; k++) begin
            if (ptr == BYTE_W'(k + 1)) begin
                rd_byte = snap_q[k];
            end
        end
    end
endmodule

// File: rtl/i2crf_slave.sv
module i2crf_slave
    import i2crf_pkg::*;
#(
    parameter logic [5:0] ADDR_HI  = 6'b101000,
    parameter int         SYNC_LEN = 2,
    parameter int         FILT_LEN = 3,
    parameter int         N_CNT    = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic                    addr_sel,
    input  logic [N_CNT*BYTE_W-1:0] cnt_live,
    input  logic [BYTE_W-1:0]       mem_rdata,
    output logic                    sda_oe,
    output logic [BYTE_W-1:0]       mem_addr,
    output logic                    mem_we,
    output logic [BYTE_W-1:0]       mem_wdata
);
    localparam int BCW = $clog2(BYTE_W + 1);

    logic scl_f, sda_f;
    logic scl_rise, scl_fall, ev_start, ev_stop;

    rf_state_t         st, st_nxt;
    logic [BYTE_W-1:0] sh_q, tx_q, ptr_q, rd_byte;
    logic [BCW-1:0]    bcnt_q;
    logic              rw_q, mack_q;
    logic              byte_done, tx_last, addr_hit, capture;
    logic              st_is_idle, in_read;
    logic [N_CNT*BYTE_W-1:0] snap_flat;

    i2crf_line_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw(scl_i), .clean(scl_f));
    i2crf_line_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw(sda_i), .clean(sda_f));

    i2crf_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .ev_start(ev_start), .ev_stop(ev_stop));

    assign byte_done = (bcnt_q == BCW'(BYTE_W));
    assign tx_last   = (bcnt_q == BCW'(BYTE_W - 1));
    assign addr_hit  = (sh_q[BYTE_W-1:1] == {ADDR_HI, addr_sel});
    assign capture   = (st == ST_DEV) && scl_fall && byte_done && addr_hit && sh_q[0]
                       && !ev_start && !ev_stop;
    assign mem_addr  = ptr_q;
    assign st_is_idle = (st == ST_IDLE);
    assign in_read    = (st == ST_READ) || (st == ST_READ_ACK);

    i2crf_snapshot #(.N_CNT(N_CNT)) u_snap (
        .clk(clk), .rst_n(rst_n), .capture(capture), .live(cnt_live),
        .ptr(ptr_q), .ext_rdata(mem_rdata), .rd_byte(rd_byte),
        .snap_flat(snap_flat));

    // next-state logic
    always_comb begin
        st_nxt = st;
        if (ev_stop) begin
            st_nxt = ST_IDLE;
        end else if (ev_start) begin
            st_nxt = ST_DEV;
        end else begin
            unique case (st)
                ST_IDLE:      st_nxt = ST_IDLE;
                ST_DEV:       if (scl_fall && byte_done) st_nxt = addr_hit ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall) st_nxt = rw_q ? ST_READ : ST_WORD;
                ST_WORD:      if (scl_fall && byte_done) st_nxt = ST_WORD_ACK;
                ST_WORD_ACK:  if (scl_fall) st_nxt = ST_WRITE;
                ST_WRITE:     if (scl_fall && byte_done) st_nxt = ST_WRITE_ACK;
                ST_WRITE_ACK: if (scl_fall) st_nxt = ST_WRITE;
                ST_READ:      if (scl_fall && tx_last) st_nxt = ST_READ_ACK;
                ST_READ_ACK:  if (scl_fall) st_nxt = mack_q ? ST_IDLE : ST_READ;
                default:      st_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            tx_q      <= '0;
            ptr_q     <= '0;
            bcnt_q    <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b1;
            sda_oe    <= 1'b0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (mem_we) ptr_q <= ptr_q + 1'b1;
            if (ev_stop) begin
                sda_oe <= 1'b0;
            end else if (ev_start) begin
                sda_oe <= 1'b0;
                bcnt_q <= '0;
            end else begin
                unique case (st)
                    ST_DEV, ST_WORD, ST_WRITE: begin
                        if (scl_rise) begin
                            sh_q   <= {sh_q[BYTE_W-2:0], sda_f};
                            bcnt_q <= bcnt_q + 1'b1;
                        end else if (scl_fall && byte_done) begin
                            bcnt_q <= '0;
                            if (st == ST_DEV) begin
                                if (addr_hit) begin
                                    sda_oe <= 1'b1;
                                    rw_q   <= sh_q[0];
                                end
                            end else if (st == ST_WORD) begin
                                sda_oe <= 1'b1;
                                ptr_q  <= sh_q;
                            end else begin
                                sda_oe    <= 1'b1;
                                mem_we    <= 1'b1;
                                mem_wdata <= sh_q;
                            end
                        end
                    end
                    ST_DEV_ACK, ST_WORD_ACK, ST_WRITE_ACK: begin
                        if (scl_fall) begin
                            bcnt_q <= '0;
                            if (st == ST_DEV_ACK && rw_q) begin
                                tx_q   <= rd_byte;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_READ: begin
                        if (scl_fall) begin
                            if (tx_last) begin
                                sda_oe <= 1'b0;
                                ptr_q  <= ptr_q + 1'b1;
                            end else begin
                                tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_q[BYTE_W-2];
                                bcnt_q <= bcnt_q + 1'b1;
                            end
                        end
                    end
                    ST_READ_ACK: begin
                        if (scl_rise) begin
                            mack_q <= sda_f;
                        end else if (scl_fall && !mack_q) begin
                            tx_q   <= rd_byte;
                            sda_oe <= ~rd_byte[BYTE_W-1];
                            bcnt_q <= '0;
                        end
                    end
                    ST_IDLE: begin
                        sda_oe <= 1'b0;
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2crf_slave_chk.sv
module i2crf_slave_chk #(
    parameter int SNAP_W = 56
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              mem_we,
    input logic [7:0]        mem_addr,
    input logic              scl_f,
    input logic              ev_start,
    input logic              ev_stop,
    input logic              st_is_idle,
    input logic              in_read,
    input logic [SNAP_W-1:0] snap_flat
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st_is_idle |-> !sda_oe);

    a_r3_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    a_r3_we_acked: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> sda_oe);

    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr == $past(mem_addr) + 8'd1));

    a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_read && $past(in_read)) |-> $stable(snap_flat));

    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> st_is_idle);

    a_r10_sda_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!scl_f || $past(ev_start) || $past(ev_stop)));
endmodule

bind i2crf_slave i2crf_slave_chk #(.SNAP_W(N_CNT*8)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .mem_we(mem_we),
    .mem_addr(mem_addr), .scl_f(scl_f), .ev_start(ev_start), .ev_stop(ev_stop),
    .st_is_idle(st_is_idle), .in_read(in_read), .snap_flat(snap_flat));

// File: tb/tb_i2crf_slave.sv
module tb_i2crf_slave;
    localparam int Q = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
    logic [55:0] cnt_live = 56'h23_45_12_09_30_59_77;
    logic [7:0]  mem_rdata, mem_addr, mem_wdata;
    logic        mem_we, sda_oe;
    wire         sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    i2crf_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel(addr_sel), .cnt_live(cnt_live), .mem_rdata(mem_rdata),
        .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata));

    // external register space and its behavioural model
    logic [7:0]  mem_arr [256];
    logic [7:0]  mdl_mem [256];
    logic [15:0] exp_wr [$];
    logic [7:0]  exp_ptr = 8'h00;
    logic [55:0] snap_m = '0;
    logic        quiet = 1'b0, bump = 1'b0, done = 1'b0;
    int          n_chk = 0, n_fail = 0;

    initial for (int i = 0; i < 256; i++) begin
        mem_arr[i] = 8'(i) ^ 8'h5A;
        mdl_mem[i] = 8'(i) ^ 8'h5A;
    end
    assign mem_rdata = mem_arr[mem_addr];
    always @(posedge clk) if (mem_we) mem_arr[mem_addr] <= mem_wdata;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the reference model
    logic prev_oe = 1'b0, prev_scl = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (exp_wr.size() == 0) check(0, "R3 unexpected write", {mem_addr, mem_wdata}, 0);
                else begin
                    logic [15:0] e;
                    e = exp_wr.pop_front();
                    check({mem_addr, mem_wdata} == e, "R3 write", {mem_addr, mem_wdata}, e);
                end
            end
            if (quiet && sda_oe) check(0, "R8 SDA driven while silent", 1, 0);
            if (scl_m && prev_scl && sda_oe != prev_oe) check(0, "R10 SDA moved with SCL high", sda_oe, prev_oe);
        end
        prev_oe  = sda_oe;
        prev_scl = scl_m;
    end

    task automatic tick(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start;
        scl_m = 0; tick(Q); sda_m = 1; tick(Q); scl_m = 1; tick(2*Q);
        sda_m = 0; tick(2*Q); scl_m = 0;
    endtask

    task automatic bus_stop;
        scl_m = 0; tick(Q); sda_m = 0; tick(Q); scl_m = 1; tick(2*Q);
        sda_m = 1; tick(2*Q);
    endtask

    task automatic put_bit(input bit b, input bit glitch);
        tick(Q); sda_m = b;
        if (glitch) begin tick(3); scl_m = 1; tick(2); scl_m = 0; tick(Q-5); end
        else tick(Q);
        scl_m = 1; tick(2*Q); scl_m = 0;
    endtask

    task automatic get_bit(output bit b);
        tick(Q); sda_m = 1; tick(Q); scl_m = 1; tick(Q); b = sda_line; tick(Q); scl_m = 0;
    endtask

    task automatic send_byte(input logic [7:0] v, input bit glitch, output bit acked);
        bit a;
        for (int i = 7; i >= 0; i--) put_bit(v[i], glitch && (i == 3));
        get_bit(a);
        acked = !a;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
        put_bit(!ack, 1'b0);
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] p);
        if (p >= 8'd1 && p <= 8'd7) return snap_m[8*(p-1) +: 8];
        return mdl_mem[p];
    endfunction

    function automatic logic [7:0] dev(input bit rw);
        return {6'b101000, addr_sel, rw};
    endfunction

    task automatic wr_seq(input logic [7:0] word, input logic [7:0] d[$], input bit glitch);
        bit a;
        bus_start;
        send_byte(dev(0), 0, a); check(a, "R2 address ack", a, 1);
        send_byte(word, 0, a);   check(a, "R3 word ack", a, 1);
        exp_ptr = word;
        foreach (d[i]) begin
            exp_wr.push_back({exp_ptr, d[i]});
            mdl_mem[exp_ptr] = d[i];
            exp_ptr = exp_ptr + 8'd1;
            send_byte(d[i], glitch, a); check(a, "R3 data ack", a, 1);
        end
        bus_stop;
    endtask

    task automatic rd_cur(input int n, input string tag);
        bit a;
        logic [7:0] v;
        bus_start;
        send_byte(dev(1), 0, a); check(a, "R2 read address ack", a, 1);
        snap_m = cnt_live;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n-1, v);
            check(v == exp_byte(exp_ptr), tag, v, exp_byte(exp_ptr));
            exp_ptr = exp_ptr + 8'd1;
            if (bump && i == 0) cnt_live = cnt_live + 56'h01_01_01_01_01_01_01;
        end
    endtask

    task automatic rd_rand(input logic [7:0] word, input int n, input string tag);
        bit a;
        bus_start;
        send_byte(dev(0), 0, a); check(a, "R5 address ack", a, 1);
        send_byte(word, 0, a);   check(a, "R5 word ack", a, 1);
        exp_ptr = word;
        rd_cur(n, tag);
    endtask

    initial begin
        bit a;
        logic [7:0] v;
        tick(5);
        check(sda_oe == 0, "R1 sda released", sda_oe, 0);
        check(mem_we == 0, "R1 no write", mem_we, 0);
        rst_n = 1; tick(20);
        check(sda_oe == 0 && mem_addr == 0, "R1 idle pointer", mem_addr, 0);

        rd_cur(2, "R6 current read from reset pointer"); bus_stop;

        wr_seq(8'h20, '{8'h11, 8'h22, 8'h33}, 0);
        rd_rand(8'h20, 3, "R5 random read"); bus_stop;

        wr_seq(8'hFE, '{8'hA1, 8'hB2, 8'hC3}, 0);
        rd_rand(8'hFF, 2, "R4 wrap FF to 00"); bus_stop;

        bump = 1; rd_rand(8'h01, 7, "R7 captured counters"); bus_stop;
        bump = 0; rd_rand(8'h01, 7, "R7 new capture"); bus_stop;

        // R2: wrong address, followed by more bytes that must be ignored
        quiet = 1;
        bus_start;
        send_byte({6'b101000, ~addr_sel, 1'b0}, 0, a); check(!a, "R2 mismatch no ack", a, 0);
        send_byte(8'h50, 0, a); check(!a, "R2 ignored byte", a, 0);
        send_byte(8'hEE, 0, a); check(!a, "R2 ignored byte", a, 0);
        bus_stop;
        quiet = 0;

        // R8: NACK ends the read; further clocking sees a released line
        rd_rand(8'h40, 1, "R8 single byte");
        quiet = 1;
        for (int i = 7; i >= 0; i--) begin bit b; get_bit(b); v[i] = b; end
        check(v == 8'hFF, "R8 released after NACK", v, 8'hFF);
        bus_stop;
        quiet = 0;
        rd_cur(1, "R8 R4 pointer after NACK"); bus_stop;

        // R9: STOP right after the word address, then current read from it
        bus_start;
        send_byte(dev(0), 0, a); check(a, "R9 address ack", a, 1);
        send_byte(8'h30, 0, a);  check(a, "R9 word ack", a, 1);
        bus_stop;
        exp_ptr = 8'h30;
        rd_cur(2, "R9 stop then read"); bus_stop;

        // R11: SCL glitches in the low phase of data bits
        wr_seq(8'h60, '{8'h96, 8'h3C}, 1);
        rd_rand(8'h60, 2, "R11 glitch-free data"); bus_stop;

        // R2: other strap value
        addr_sel = 1;
        wr_seq(8'h70, '{8'h5E}, 0);
        rd_rand(8'h70, 1, "R2 strap address"); bus_stop;

        tick(40);
        check(exp_wr.size() == 0, "R3 all writes seen", exp_wr.size(), 0);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule